// File: doc/BRIEF.md
# Row Refresh Sequencer

This block keeps the charge in a banked memory array alive by refreshing rows in turn. The banks are organised into bank groups. Each refresh tick starts one refresh operation, and that operation covers one bank in every group at the same moment. In each group the chosen bank is marked busy, and the other banks of the group stay available to the access controller. The bank index rotates round-robin from one operation to the next. Each bank keeps its own row counter, so every bank walks through all of its rows in ascending order and wraps back to zero.

An operation always runs four phases, in this order: close any open row, precharge the bitlines, activate the target row, and let sensing restore the cells. Each phase lasts a fixed number of cycles. The sequencer sends one command pulse to the array model at the start of each phase. If the chosen bank had a row open, the close phase closes it and pulses a clear for that bank's open-row tag in the access controller. When the final bank has refreshed its final row, a one-cycle flag reports that a full pass is done.

Top module: `row_refresh_seq`

## Requirements
- R1: A refresh tick sampled while idle starts an operation. In the next cycle `bank_busy` has exactly one bit set per group, at flat index g*BANKS_PER_GROUP+b, where b is the rotating bank index.
- R2: Command pulses arrive STEP_CYC cycles apart, starting in the first busy cycle. Their order and codes are close (1), precharge (2), activate (3), sense (4). `cmd_op` is 0 (no-op) in every other cycle.
- R3: The close pulse is issued only when at least one chosen bank has its `row_open` bit set. Otherwise the first slot carries code 0. In the first busy cycle, `cmd_grp_mask` bit g shows whether group g's chosen bank was open, and `tag_clear` pulses for exactly the chosen banks that were open.
- R4: `bank_busy` stays constant for exactly 4*STEP_CYC cycles and then returns to zero.
- R5: While an operation runs, `cmd_row` field g (bits g*ROW_W upward) holds the row counter of group g's chosen bank. That counter increments by one after each operation on the bank and wraps from its maximum to 0.
- R6: The bank index starts at 0 and advances by one after each operation, wrapping after the last bank of the group. `cmd_bank` shows it.
- R7: A refresh tick that arrives while an operation is running is ignored. It neither extends the operation nor advances the bank index or the row counters.
- R8: `pass_done` pulses for one cycle, in the first idle cycle after the operation that refreshes the last row of the last bank index, and at no other time.
- R9: After a synchronous reset, `bank_busy`, `tag_clear` and `pass_done` are 0, `cmd_op` is 0, and every row counter and the bank index are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| refresh_tick | input | 1 | Request to start one refresh operation |
| row_open | input | NB | Access controller open-row tags, one per bank |
| bank_busy | output | NB | Banks currently under refresh, stall accesses |
| tag_clear | output | NB | Pulse clearing the open-row tag of a closed bank |
| cmd_op | output | 3 | Phase command to the array (0 none, 1 close, 2 precharge, 3 activate, 4 sense) |
| cmd_grp_mask | output | NUM_GROUPS | Groups addressed by the current command |
| cmd_bank | output | BIDX_W | Bank index within each group |
| cmd_row | output | NUM_GROUPS*ROW_W | Row address, one field per group |
| pass_done | output | 1 | One-cycle pulse after a complete pass over all rows |

## Verification
A corrupted row counter shows up on `cmd_row` the next time that bank is refreshed, which can be up to BANKS_PER_GROUP operations later. It also moves the `pass_done` pulse to the wrong operation. A slipped bank index shows up in the very next busy cycle as the wrong `bank_busy` pattern and the wrong `cmd_bank`. A phase-timer fault changes where the command pulses land and how long busy lasts, and it shows within one operation. The sweep covers two full passes with a changing open-row pattern, so every counter value, every bank index and both wraps are seen at the ports.

// File: rtl/rrs_pkg.sv
package rrs_pkg;
  typedef enum logic [2:0] {
    OP_NOP   = 3'd0,
    OP_CLOSE = 3'd1,
    OP_PRECH = 3'd2,
    OP_ACT   = 3'd3,
    OP_SENSE = 3'd4
  } ref_op_e;
endpackage

// File: rtl/rrs_step_fsm.sv
// Four-phase timer: each phase lasts STEP_CYC cycles.
module rrs_step_fsm #(
  parameter int STEP_CYC = 4,
  localparam int TCW = (STEP_CYC > 1) ? $clog2(STEP_CYC) : 1
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       start,
  output logic       accept,
  output logic       active,
  output logic [1:0] step,
  output logic       step_new,
  output logic       finish
);
  logic [TCW-1:0] tcnt;
  logic           last;

  assign last   = (tcnt == TCW'(STEP_CYC - 1));
  assign accept = start && !active;
  assign finish = active && (step == 2'd3) && last;

  always_ff @(posedge clk) begin
    if (rst) begin
      active   <= 1'b0;
      step     <= 2'd0;
      tcnt     <= '0;
      step_new <= 1'b0;
    end else begin
      step_new <= 1'b0;
      if (accept) begin
        active   <= 1'b1;
        step     <= 2'd0;
        tcnt     <= '0;
        step_new <= 1'b1;
      end else if (active) begin
        if (last) begin
          tcnt <= '0;
          if (step == 2'd3) begin
            active <= 1'b0;
          end else begin
            step     <= step + 2'd1;
            step_new <= 1'b1;
          end
        end else begin
          tcnt <= tcnt + TCW'(1);
        end
      end
    end
  end
endmodule

// File: rtl/rrs_bank_rotor.sv
// Round-robin bank index shared by all groups.
module rrs_bank_rotor #(
  parameter int BANKS_PER_GROUP = 4,
  localparam int BIDX_W = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              adv,
  output logic [BIDX_W-1:0] idx,
  output logic              at_last
);
  assign at_last = (idx == BIDX_W'(BANKS_PER_GROUP - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
    end else if (adv) begin
      idx <= at_last ? '0 : idx + BIDX_W'(1);
    end
  end
endmodule

// File: rtl/rrs_row_table.sv
// Row counters, one per bank, advanced for the chosen bank of every group.
module rrs_row_table #(
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ROW_W           = 16,
  localparam int NB     = NUM_GROUPS * BANKS_PER_GROUP,
  localparam int BIDX_W = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        adv,
  input  logic [BIDX_W-1:0]           idx,
  output logic [NUM_GROUPS*ROW_W-1:0] row_sel,
  output logic                        row_at_max
);
  logic [ROW_W-1:0] rows [NB];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NB; i++) rows[i] <= '0;
    end else if (adv) begin
      for (int g = 0; g < NUM_GROUPS; g++) begin
        rows[g*BANKS_PER_GROUP + int'(idx)] <= rows[g*BANKS_PER_GROUP + int'(idx)] + ROW_W'(1);
      end
    end
  end

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_sel
    assign row_sel[g*ROW_W +: ROW_W] = rows[g*BANKS_PER_GROUP + int'(idx)];
  end

  assign row_at_max = &rows[int'(idx)];
endmodule

// File: rtl/row_refresh_seq.sv
module row_refresh_seq #(
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ROW_W           = 16,
  parameter int STEP_CYC        = 4,
  localparam int NB     = NUM_GROUPS * BANKS_PER_GROUP,
  localparam int BIDX_W = (BANKS_PER_GROUP > 1) ? $clog2(BANKS_PER_GROUP) : 1
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        refresh_tick,
  input  logic [NB-1:0]               row_open,
  output logic [NB-1:0]               bank_busy,
  output logic [NB-1:0]               tag_clear,
  output logic [2:0]                  cmd_op,
  output logic [NUM_GROUPS-1:0]       cmd_grp_mask,
  output logic [BIDX_W-1:0]           cmd_bank,
  output logic [NUM_GROUPS*ROW_W-1:0] cmd_row,
  output logic                        pass_done
);
  import rrs_pkg::*;

  logic              accept, active, step_new, finish;
  logic [1:0]        step;
  logic [BIDX_W-1:0] idx;
  logic              idx_last, row_at_max;
  logic [NB-1:0]     sel;
  logic [NUM_GROUPS-1:0] close_mask, open_hit;
  ref_op_e           op_now;

  rrs_step_fsm #(.STEP_CYC(STEP_CYC)) u_fsm (
    .clk(clk), .rst(rst), .start(refresh_tick), .accept(accept),
    .active(active), .step(step), .step_new(step_new), .finish(finish)
  );

  rrs_bank_rotor #(.BANKS_PER_GROUP(BANKS_PER_GROUP)) u_rotor (
    .clk(clk), .rst(rst), .adv(finish), .idx(idx), .at_last(idx_last)
  );

  rrs_row_table #(
    .NUM_GROUPS(NUM_GROUPS), .BANKS_PER_GROUP(BANKS_PER_GROUP), .ROW_W(ROW_W)
  ) u_rows (
    .clk(clk), .rst(rst), .adv(finish), .idx(idx),
    .row_sel(cmd_row), .row_at_max(row_at_max)
  );

  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_grp
    for (genvar b = 0; b < BANKS_PER_GROUP; b++) begin : g_bank
      assign sel[g*BANKS_PER_GROUP + b] = (idx == BIDX_W'(b));
    end
    assign open_hit[g] = |(row_open[g*BANKS_PER_GROUP +: BANKS_PER_GROUP]
                           & sel[g*BANKS_PER_GROUP +: BANKS_PER_GROUP]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bank_busy  <= '0;
      tag_clear  <= '0;
      close_mask <= '0;
      pass_done  <= 1'b0;
    end else begin
      tag_clear <= '0;
      pass_done <= 1'b0;
      if (accept) begin
        bank_busy  <= sel;
        tag_clear  <= row_open & sel;
        close_mask <= open_hit;
      end else if (finish) begin
        bank_busy <= '0;
        pass_done <= idx_last && row_at_max;
      end
    end
  end

  always_comb begin
    op_now = OP_NOP;
    if (step_new) begin
      case (step)
        2'd0:    op_now = (close_mask != '0) ? OP_CLOSE : OP_NOP;
        2'd1:    op_now = OP_PRECH;
        2'd2:    op_now = OP_ACT;
        default: op_now = OP_SENSE;
      endcase
    end
  end

  assign cmd_op       = op_now;
  assign cmd_grp_mask = (step == 2'd0) ? close_mask : '1;
  assign cmd_bank     = idx;
endmodule

// File: rtl/rrs_checker.sv
module rrs_checker #(
  parameter int NUM_GROUPS      = 4,
  parameter int BANKS_PER_GROUP = 4,
  parameter int ROW_W           = 16,
  localparam int NB = NUM_GROUPS * BANKS_PER_GROUP
) (
  input logic                        clk,
  input logic                        rst,
  input logic [NB-1:0]               bank_busy,
  input logic [NB-1:0]               tag_clear,
  input logic [2:0]                  cmd_op,
  input logic [NUM_GROUPS*ROW_W-1:0] cmd_row,
  input logic                        pass_done
);
  for (genvar g = 0; g < NUM_GROUPS; g++) begin : g_chk
    p_one_per_group_r1: assert property (@(posedge clk) disable iff (rst)
      $onehot0(bank_busy[g*BANKS_PER_GROUP +: BANKS_PER_GROUP]));
  end

  p_tag_in_busy_r3: assert property (@(posedge clk) disable iff (rst)
    (tag_clear & ~bank_busy) == '0);

  p_tag_with_close_r3: assert property (@(posedge clk) disable iff (rst)
    (tag_clear != '0) |-> (cmd_op == 3'd1));

  p_busy_steady_r4: assert property (@(posedge clk) disable iff (rst)
    (bank_busy != '0) |=> (bank_busy == '0) || $stable(bank_busy));

  p_row_steady_r5: assert property (@(posedge clk) disable iff (rst)
    (bank_busy != '0) |=> (bank_busy == '0) || $stable(cmd_row));

  p_op_only_busy_r2: assert property (@(posedge clk) disable iff (rst)
    (cmd_op != 3'd0) |-> (bank_busy != '0));

  p_done_pulse_r8: assert property (@(posedge clk) disable iff (rst)
    pass_done |=> !pass_done);

  p_done_idle_r8: assert property (@(posedge clk) disable iff (rst)
    pass_done |-> (bank_busy == '0));
endmodule

bind row_refresh_seq rrs_checker #(
  .NUM_GROUPS(NUM_GROUPS), .BANKS_PER_GROUP(BANKS_PER_GROUP), .ROW_W(ROW_W)
) u_chk (
  .clk(clk), .rst(rst), .bank_busy(bank_busy), .tag_clear(tag_clear),
  .cmd_op(cmd_op), .cmd_row(cmd_row), .pass_done(pass_done)
);

// File: tb/row_refresh_seq_tb_top.sv
module row_refresh_seq_tb_top;
  localparam int NG   = 2;
  localparam int BPG  = 2;
  localparam int RW   = 2;
  localparam int S    = 2;
  localparam int NB   = NG * BPG;
  localparam int NROW = 1 << RW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic refresh_tick = 1'b0;
  logic [NB-1:0] row_open = '0;
  logic [NB-1:0] bank_busy, tag_clear;
  logic [2:0] cmd_op;
  logic [NG-1:0] cmd_grp_mask;
  logic [0:0] cmd_bank;
  logic [NG*RW-1:0] cmd_row;
  logic pass_done;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  row_refresh_seq #(.NUM_GROUPS(NG), .BANKS_PER_GROUP(BPG), .ROW_W(RW), .STEP_CYC(S)) dut_i (
    .clk(clk), .rst(rst), .refresh_tick(refresh_tick), .row_open(row_open),
    .bank_busy(bank_busy), .tag_clear(tag_clear), .cmd_op(cmd_op),
    .cmd_grp_mask(cmd_grp_mask), .cmd_bank(cmd_bank), .cmd_row(cmd_row),
    .pass_done(pass_done)
  );

  task automatic check(input logic [31:0] act, input logic [31:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual timeout expected completion");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin : stim
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R9 reset state
    check(32'(bank_busy), 0, "R9 busy");
    check(32'(tag_clear), 0, "R9 tag");
    check(32'(cmd_op), 0, "R9 op");
    check(32'(pass_done), 0, "R9 done");
    check(32'(cmd_bank), 0, "R9 bank");
    check(32'(cmd_row), 0, "R9 row");

    for (int i = 0; i < 2 * NROW * BPG; i++) begin
      int b, row, first_op;
      logic [NB-1:0] pat, exp_busy;
      logic [NG-1:0] exp_grp;
      logic [NG*RW-1:0] exp_row;
      b   = i % BPG;
      row = (i / BPG) % NROW;
      pat = NB'(i * 5 + 3);
      exp_busy = '0;
      exp_grp  = '0;
      for (int g = 0; g < NG; g++) begin
        exp_busy[g*BPG + b] = 1'b1;
        exp_grp[g] = pat[g*BPG + b];
        exp_row[g*RW +: RW] = RW'(row);
      end
      first_op = (exp_grp != '0) ? 1 : 0;

      row_open = pat;
      refresh_tick = 1'b1;
      @(negedge clk);
      refresh_tick = 1'b0;
      for (int j = 0; j < 4 * S; j++) begin
        int exp_op;
        if (j % S != 0) exp_op = 0;
        else if (j == 0) exp_op = first_op;
        else exp_op = 1 + j / S;
        check(32'(bank_busy), 32'(exp_busy), "R1 R4 busy pattern");
        check(32'(cmd_op), 32'(exp_op), "R2 phase command");
        check(32'(cmd_row), 32'(exp_row), "R5 row address");
        check(32'(cmd_bank), 32'(b), "R6 bank index");
        check(32'(pass_done), 0, "R8 no early done");
        if (j == 0) begin
          check(32'(tag_clear), 32'(pat & exp_busy), "R3 tag clear");
          check(32'(cmd_grp_mask), 32'(exp_grp), "R3 close groups");
        end else begin
          check(32'(tag_clear), 0, "R3 tag idle");
        end
        // R7: tick while busy must be ignored
        refresh_tick = (j == 2);
        @(negedge clk);
      end
      refresh_tick = 1'b0;
      check(32'(bank_busy), 0, "R4 busy release");
      check(32'(cmd_op), 0, "R7 no restart");
      check(32'(pass_done), 32'((i % (NROW * BPG)) == NROW * BPG - 1), "R8 pass done");
    end
    check(32'(cmd_bank), 0, "R6 wrap");
    check(32'(cmd_row), 0, "R5 wrap");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule